// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block sends bytes on one asynchronous serial line. Each character goes out as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. The line is high when idle. An 8-bit format register sets the character layout while the block runs. Software writes it and reads it back through a plain write-enable and write-data port, and the current value is always present on a read-data output.

Bytes come in over a valid/ready handshake. An outside baud divisor supplies a timing pulse at sixteen times the bit rate. Each bit lasts sixteen of these pulses. This gives the half-bit resolution that a stop period of one and a half bits needs. The format is captured when a byte is accepted, so a register write made during a character only applies to the next one. A break control in the register holds the line low for as long as it is set, and while it is set no new byte is accepted.

Top module: `uft_top`

## Requirements
- R1: After reset the format register reads 0x00, `tx` is 1 and `in_ready` is 1.
- R2: A write with `reg_we` high stores all eight bits of `reg_wdata`. The value appears on `reg_rdata` in the following cycle.
- R3: A character is one start bit of 0, then the data bits with bit 0 first. Register bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the word length are not sent. The line is 1 between characters.
- R4: When register bit [3] is 0, no parity bit is sent, whatever bits [5:4] hold.
- R5: Register bits [5:3] = 001 send a parity bit that makes the count of ones across the data and parity bits odd. The value 011 makes that count even.
- R6: Register bits [5:3] = 101 always send a parity bit of 1. The value 111 always sends 0.
- R7: Every start, data and parity bit lasts 16 `tick16` pulses. With register bit [2] = 0 the stop period is 16 pulses. With bit [2] = 1 it is 24 pulses for 5-bit words and 32 pulses for 6, 7 and 8-bit words.
- R8: While register bit [6] is 1, `tx` is 0 and `in_ready` is 0. When the bit is cleared, the line returns high and bytes are accepted again.
- R9: Register bit [7] is stored and read back, but it has no effect on the line.
- R10: A register write made while a character is being sent leaves the rest of that character unchanged. The new format applies from the next start bit.
- R11: `in_ready` is 1 only when no character is in progress and break is clear. It drops in the cycle after a byte is accepted and stays 0 until the stop period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| reg_we | input | 1 | Format register write strobe |
| reg_wdata | input | 8 | Format register write value |
| reg_rdata | output | 8 | Current format register value |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte accepted when both valid and ready are 1 |
| tx | output | 1 | Serial line output |

## Verification
Each frame check samples the line in the middle of every bit period and counts `tick16` pulses from acceptance until `in_ready` returns. The bit-value check separates the word length, the bit order and the parity settings. The pulse count separates the 16-, 24- and 32-pulse stop periods, which have the same line level. The bytes used set bits above the word length, carry both odd and even counts of ones, and are sent under both parity senses, both stick values, and parity disabled with bits [5:4] set. A register write in the middle of a character, the divisor-latch bit, and break with a byte held on the input check that the line and the handshake ignore what they must ignore.

// File: rtl/uft_pkg.sv
// Package: shared types for the programmable-format transmitter.
// Assumes: at most 8 data bits per character, stop period given in half bits.
package uft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_CALC,
        PK_ONE,
        PK_ZERO
    } par_kind_e;

    typedef struct packed {
        logic [3:0] nbits;      // data bits, 5..8
        par_kind_e  pkind;      // parity source
        logic       par_odd;    // computed parity sense: 1 = odd
        logic [2:0] stop_half;  // stop length in half bits: 2, 3 or 4
    } fmt_t;

endpackage

// File: rtl/uft_ctrl_reg.sv
// Module: format register and its decode.
// Stores the 8-bit control value, returns it for readback and decodes the
// character format and the break flag. Assumes a synchronous active-low reset.
module uft_ctrl_reg
    import uft_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] rdata,
    output fmt_t          fmt,
    output logic          brk
);

    logic [RW-1:0] ctl_q;

    // Purpose: hold the control value, loaded by a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wdata;
        end
    end

    assign rdata = ctl_q;
    assign brk   = ctl_q[6];

    // Purpose: turn the raw bits into word length, parity kind and stop length.
    always_comb begin
        fmt.nbits   = 4'd5 + {2'b00, ctl_q[1:0]};
        fmt.par_odd = ~ctl_q[4];
        if (!ctl_q[3]) begin
            fmt.pkind = PK_NONE;
        end else if (ctl_q[5]) begin
            fmt.pkind = ctl_q[4] ? PK_ZERO : PK_ONE;
        end else begin
            fmt.pkind = PK_CALC;
        end
        if (!ctl_q[2]) begin
            fmt.stop_half = 3'd2;
        end else if (ctl_q[1:0] == 2'b00) begin
            fmt.stop_half = 3'd3;
        end else begin
            fmt.stop_half = 3'd4;
        end
    end

endmodule

// File: rtl/uft_parity.sv
// Module: parity bit generator.
// Masks the byte to the selected word length and forms the parity bit for the
// selected kind. Purely combinational. Assumes nbits <= DW.
module uft_parity
    import uft_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  fmt_t          fmt,
    output logic          par
);

    localparam int NW = $clog2(DW + 1);

    logic [DW-1:0] masked;
    logic          ones_odd;

    // Purpose: drop data bits that lie above the word length.
    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign masked[i] = data[i] & (NW'(i) < NW'(fmt.nbits));
    end

    assign ones_odd = ^masked;

    // Purpose: choose computed, stuck-one or stuck-zero parity.
    always_comb begin
        unique case (fmt.pkind)
            PK_CALC: par = fmt.par_odd ? ~ones_odd : ones_odd;
            PK_ONE:  par = 1'b1;
            PK_ZERO: par = 1'b0;
            default: par = 1'b0;
        endcase
    end

endmodule

// File: rtl/uft_shifter.sv
// Module: frame sequencer and shift register.
// Captures a byte, its parity bit and the format when loaded, then steps
// through start, data, parity and stop periods counted in oversample ticks.
// Assumes OSR is even so that a half bit is a whole number of ticks.
module uft_shifter
    import uft_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_par,
    input  fmt_t          load_fmt,
    output logic          idle,
    output logic          line_bit
);

    localparam int HALF  = OSR / 2;
    localparam int CNT_W = $clog2(2 * OSR) + 1;
    localparam int IDX_W = $clog2(DW + 1);

    tx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    sh_q;
    logic             par_q;
    fmt_t             fmt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             period_end;

    // Purpose: length of the current period, minus one, in ticks.
    always_comb begin
        if (state_q == ST_STOP) begin
            last_cnt = CNT_W'(fmt_q.stop_half) * CNT_W'(HALF) - CNT_W'(1);
        end else begin
            last_cnt = CNT_W'(OSR - 1);
        end
    end

    assign period_end = tick && (cnt_q == last_cnt);

    // Purpose: advance through the frame one tick at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            fmt_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (load) begin
                sh_q    <= load_data;
                par_q   <= load_par;
                fmt_q   <= load_fmt;
                cnt_q   <= '0;
                idx_q   <= '0;
                state_q <= ST_START;
            end
        end else if (tick) begin
            if (period_end) begin
                cnt_q <= '0;
                unique case (state_q)
                    ST_START: state_q <= ST_DATA;
                    ST_DATA: begin
                        sh_q <= sh_q >> 1;
                        if (idx_q == IDX_W'(fmt_q.nbits) - IDX_W'(1)) begin
                            idx_q   <= '0;
                            state_q <= (fmt_q.pkind != PK_NONE) ? ST_PAR : ST_STOP;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                    ST_PAR:  state_q <= ST_STOP;
                    ST_STOP: state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign idle = (state_q == ST_IDLE);

    // Purpose: line level for the current period.
    always_comb begin
        unique case (state_q)
            ST_START: line_bit = 1'b0;
            ST_DATA:  line_bit = sh_q[0];
            ST_PAR:   line_bit = par_q;
            default:  line_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/uft_top.sv
// Module: programmable-format serial transmitter, top level.
// Joins the format register, parity generator and frame sequencer, gates the
// input handshake and applies break to the line. Assumes tick16 is a
// one-cycle pulse at OSR times the bit rate.
module uft_top
    import uft_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          tx
);

    fmt_t fmt;
    logic brk;
    logic par_bit;
    logic sh_idle;
    logic line_bit;
    logic accept;

    uft_ctrl_reg #(.RW(8)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .fmt   (fmt),
        .brk   (brk)
    );

    uft_parity #(.DW(DW)) u_par (
        .data (in_data),
        .fmt  (fmt),
        .par  (par_bit)
    );

    assign in_ready = sh_idle && !brk;
    assign accept   = in_valid && in_ready;

    uft_shifter #(.DW(DW), .OSR(OSR)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .load      (accept),
        .load_data (in_data),
        .load_par  (par_bit),
        .load_fmt  (fmt),
        .idle      (sh_idle),
        .line_bit  (line_bit)
    );

    // Purpose: break overrides the sequencer and holds the line low.
    assign tx = brk ? 1'b0 : line_bit;

endmodule

// File: rtl/uft_checker.sv
// Module: property checker for uft_top, attached through bind.
// Observes ports only. Assumes a synchronous active-low reset.
module uft_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       in_valid,
    input logic       in_ready,
    input logic       tx
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 8'h00 && tx && in_ready));

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata == $past(reg_wdata)));

    assert_break_line_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6] |-> !tx);

    assert_break_blocks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6] |-> !in_ready);

    assert_ready_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx);

endmodule

bind uft_top uft_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx        (tx)
);

// File: tb/sim_uft_top.sv
// Bench: directed tests for uft_top, one task per scenario.
module sim_uft_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       tx;

    int total = 0;
    int bad = 0;
    int tickcnt = 0;
    int ph = 0;

    uft_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .tx        (tx)
    );

    always #4 clk = ~clk;

    // tick pulse every fourth cycle, driven away from the active edge
    always @(negedge clk) begin
        ph     <= (ph + 1) % 4;
        tick16 <= (ph == 3);
    end

    always @(posedge clk) if (tick16) tickcnt <= tickcnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_tick(input int target);
        while (tickcnt < target) @(negedge clk);
    endtask

    // offer a byte and return the tick count at acceptance
    task automatic accept(input logic [7:0] d, output int t0);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        t0 = tickcnt;
        check(in_ready == 1'b0, "R11 ready drop after accept", in_ready, 0);
    endtask

    // verify the frame from bit kfrom onward against format lcr
    task automatic check_frame(input logic [7:0] d, input logic [7:0] lcr,
                               input int t0, input int kfrom, input string req);
        int nb;
        int nbits_all;
        int stop_t;
        int t1;
        logic [11:0] exp_bits;
        logic pbit;
        logic [7:0] m;
        nb = 5 + int'(lcr[1:0]);
        m  = d & 8'((1 << nb) - 1);
        exp_bits = '0;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) exp_bits[i+1] = d[i];
        nbits_all = 1 + nb;
        if (lcr[3]) begin
            if (lcr[5]) pbit = ~lcr[4];
            else        pbit = lcr[4] ? (^m) : ~(^m);
            exp_bits[nbits_all] = pbit;
            nbits_all++;
        end
        stop_t = !lcr[2] ? 16 : (nb == 5 ? 24 : 32);
        for (int k = kfrom; k < nbits_all; k++) begin
            wait_tick(t0 + 16 * k + 8);
            check(tx == exp_bits[k], req, tx, exp_bits[k]);
        end
        wait_tick(t0 + 16 * nbits_all + 8);
        check(tx == 1'b1, "R7 stop level", tx, 1);
        while (!in_ready) @(negedge clk);
        t1 = tickcnt;
        check((t1 - t0) == 16 * nbits_all + stop_t, "R7 frame length in ticks",
              t1 - t0, 16 * nbits_all + stop_t);
        check(tx == 1'b1, "R3 idle line high", tx, 1);
    endtask

    task automatic send(input logic [7:0] lcr, input logic [7:0] d, input string req);
        int t0;
        write_reg(lcr);
        accept(d, t0);
        check_frame(d, lcr, t0, 0, req);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(reg_rdata == 8'h00, "R1 reg reset", reg_rdata, 0);
        check(tx == 1'b1, "R1 tx reset", tx, 1);
        check(in_ready == 1'b1, "R1 ready reset", in_ready, 1);
    endtask

    task automatic test_readback();
        write_reg(8'hA5);
        check(reg_rdata == 8'hA5, "R2 readback", reg_rdata, 8'hA5);
        write_reg(8'h5A);
        check(reg_rdata == 8'h5A, "R2 readback", reg_rdata, 8'h5A);
    endtask

    task automatic test_lengths();
        send(8'h03, 8'hA5, "R3 8-bit word");
        send(8'h00, 8'hF3, "R3 5-bit word upper bits dropped");
        send(8'h01, 8'hC6, "R3 6-bit word");
        send(8'h02, 8'h9D, "R3 7-bit word");
    endtask

    task automatic test_parity();
        send(8'h33, 8'h5B, "R4 parity off with [5:4] set");
        send(8'h0A, 8'h35, "R5 odd parity 7-bit");
        send(8'h1B, 8'h35, "R5 even parity 8-bit");
        send(8'h0B, 8'h01, "R5 odd parity 8-bit");
        send(8'h2B, 8'h00, "R6 stick one");
        send(8'h3B, 8'hFF, "R6 stick zero");
    endtask

    task automatic test_stops();
        send(8'h04, 8'h15, "R7 5-bit one-and-half stop");
        send(8'h05, 8'h2A, "R7 6-bit two stop");
        send(8'h07, 8'h81, "R7 8-bit two stop");
    endtask

    task automatic test_dlab();
        send(8'h83, 8'hC3, "R9 bit7 no effect");
    endtask

    task automatic test_midframe();
        int t0;
        write_reg(8'h03);
        accept(8'h5A, t0);
        wait_tick(t0 + 40);
        write_reg(8'h0C);
        check_frame(8'h5A, 8'h03, t0, 3, "R10 frame unchanged by write");
        send(8'h0C, 8'h0B, "R10 new format on next frame");
    endtask

    task automatic test_break();
        write_reg(8'h43);
        check(tx == 1'b0, "R8 break line low", tx, 0);
        check(in_ready == 1'b0, "R8 break blocks ready", in_ready, 0);
        in_valid = 1'b1;
        in_data  = 8'hEE;
        repeat (40) @(negedge clk);
        check(in_ready == 1'b0, "R8 ready held low", in_ready, 0);
        check(tx == 1'b0, "R8 line held low", tx, 0);
        in_valid = 1'b0;
        write_reg(8'h03);
        check(tx == 1'b1, "R8 line high after clear", tx, 1);
        check(in_ready == 1'b1, "R8 ready after clear", in_ready, 1);
        send(8'h03, 8'h69, "R8 send after break");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_readback();
        test_lengths();
        test_parity();
        test_stops();
        test_dlab();
        test_midframe();
        test_break();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule